// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block watches received Ethernet frames byte by byte as they leave a MAC receive path and delivers one accept or drop verdict per frame. Layer 2 acceptance needs the destination MAC to equal the station address or an enabled entry of a small multicast table. Layer 2 acceptance is required, and a frame that has it is then judged by an ordered list of layer 3/4 rules. Each rule compares the IPv4 source or destination address, or the TCP/UDP source or destination port, against a programmed value. Each rule has its own pass or discard action, and a programmable default covers frames that no rule matches.

Rules and addresses are loaded through a write-only word interface. Bytes arrive with a valid qualifier, a start marker on the first byte and an end marker on the last. An error flag may be raised on any byte of the frame. The verdict is a one-cycle pulse in the cycle after the last byte.

Top module: `eth_frame_filter`

## Requirements
- R1: `verdict_valid` is high for exactly the cycle after a frame's last byte (`in_valid` with `in_eof`) is accepted, and at no other time; `verdict_pass` is never high without it. Bytes with `in_valid` that arrive outside a frame (after an end marker, before the next start marker) are ignored and yield no verdict.
- R2: A frame whose first six bytes (first byte = most significant) equal the station address is accepted at layer 2.
- R3: The multicast table has 8 entries, each with its own valid bit; a frame whose destination equals a valid entry is accepted at layer 2, and an entry whose valid bit is clear never matches.
- R4: A frame that is not accepted at layer 2, including any frame shorter than 6 bytes, is dropped whatever the rules say.
- R5: IPv4 fields are examined only when bytes 12-13 hold EtherType 0x0800 and the header length nibble (low nibble of byte 14) is at least 5. Source address is bytes 26-29 and destination address is bytes 30-33. Ports start at byte 14 + 4*IHL (source port first) and are examined only when byte 23 is 6 or 17.
- R6: Each rule has a kind: 0 compares the IPv4 source address, 1 the IPv4 destination address, 2 the L4 source port, 3 the L4 destination port (ports against the value's low 16 bits).
- R7: Rules are evaluated in index order; the action of the lowest-index enabled matching rule decides (1 = pass, 0 = discard).
- R8: If no enabled rule matches (including every non-IPv4 frame), the default action decides.
- R9: A rule whose enable bit is clear never matches.
- R10: A frame that ends before the last byte of a field a rule examines does not match that rule.
- R11: A frame with `in_err` high on any of its bytes is always dropped.
- R12: Configuration words: address 0 = station address bits 31:0, address 1 = bits 47:32 (data bits 15:0), address 2 bit 0 = default action; multicast entry i: address 8+2i = bits 31:0, 9+2i = bits 47:32 in data 15:0 and valid in data bit 16; rule i: address 24+2i = compare value, 25+2i = kind in bits 1:0, action in bit 3, enable in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte qualifier |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Receive error on this byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| verdict_valid | output | 1 | Verdict pulse |
| verdict_pass | output | 1 | Frame accepted (valid with the pulse) |

## Verification
Every verdict is due one cycle after the end-marked byte is clocked in: the bench drives bytes on falling edges and reads both outputs on the falling edge that follows the last byte, which lies after the one register stage. Configuration writes take effect at the edge that samples them, so each scenario finishes its writes before its first byte. Truncated frames are cut one byte short of and exactly at the end of a compared field, so the length cut-off is checked on both sides.

// File: rtl/eth_frame_filter.sv
module eth_frame_filter #(
  parameter int MC_N   = 8,
  parameter int RULE_N = 4,
  parameter int CNT_W  = 11,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              verdict_valid,
  output logic              verdict_pass
);
  localparam int MC_BASE   = 8;
  localparam int RULE_BASE = MC_BASE + 2 * MC_N;

  logic [47:0] sta_mac;
  logic        dflt_pass;
  logic [47:0] mc_addr [MC_N];
  logic [MC_N-1:0] mc_vld;
  logic [31:0] rule_val [RULE_N];
  logic [1:0]  rule_kind [RULE_N];
  logic [RULE_N-1:0] rule_en, rule_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_mac   <= '0;
      dflt_pass <= 1'b0;
      mc_vld    <= '0;
      rule_en   <= '0;
      rule_act  <= '0;
      for (int i = 0; i < MC_N; i++) mc_addr[i] <= '0;
      for (int i = 0; i < RULE_N; i++) begin
        rule_val[i]  <= '0;
        rule_kind[i] <= '0;
      end
    end else if (cfg_we) begin
      if (int'(cfg_addr) == 0) sta_mac[31:0]  <= cfg_wdata;
      if (int'(cfg_addr) == 1) sta_mac[47:32] <= cfg_wdata[15:0];
      if (int'(cfg_addr) == 2) dflt_pass      <= cfg_wdata[0];
      for (int i = 0; i < MC_N; i++) begin
        if (int'(cfg_addr) == MC_BASE + 2 * i) mc_addr[i][31:0] <= cfg_wdata;
        if (int'(cfg_addr) == MC_BASE + 2 * i + 1) begin
          mc_addr[i][47:32] <= cfg_wdata[15:0];
          mc_vld[i]         <= cfg_wdata[16];
        end
      end
      for (int i = 0; i < RULE_N; i++) begin
        if (int'(cfg_addr) == RULE_BASE + 2 * i) rule_val[i] <= cfg_wdata;
        if (int'(cfg_addr) == RULE_BASE + 2 * i + 1) begin
          rule_kind[i] <= cfg_wdata[1:0];
          rule_act[i]  <= cfg_wdata[3];
          rule_en[i]   <= cfg_wdata[4];
        end
      end
    end
  end

  logic             in_frame, err_q, pend;
  logic [CNT_W-1:0] cnt;
  logic [47:0]      dmac;
  logic [15:0]      etype, sport, dport;
  logic [3:0]       ihl;
  logic [7:0]       proto;
  logic [31:0]      sip, dip;

  wire              take = in_valid && (in_sof || in_frame);
  wire  [CNT_W-1:0] idx  = in_sof ? '0 : cnt;
  wire  [31:0]      ix   = 32'(idx);
  wire  [31:0]      len  = 32'(cnt);
  wire  [31:0]      l4   = 32'd14 + {26'd0, ihl, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      err_q    <= 1'b0;
      pend     <= 1'b0;
      cnt      <= '0;
      dmac     <= '0;
      etype    <= '0;
      ihl      <= '0;
      proto    <= '0;
      sip      <= '0;
      dip      <= '0;
      sport    <= '0;
      dport    <= '0;
    end else begin
      pend <= take && in_eof;
      if (take) begin
        in_frame <= !in_eof;
        cnt      <= (idx == '1) ? idx : idx + 1'b1;
        err_q    <= (err_q && !in_sof) || in_err;
        if (ix < 32'd6)                     dmac  <= {dmac[39:0], in_data};
        if (ix == 32'd12 || ix == 32'd13)   etype <= {etype[7:0], in_data};
        if (ix == 32'd14)                   ihl   <= in_data[3:0];
        if (ix == 32'd23)                   proto <= in_data;
        if (ix >= 32'd26 && ix < 32'd30)    sip   <= {sip[23:0], in_data};
        if (ix >= 32'd30 && ix < 32'd34)    dip   <= {dip[23:0], in_data};
        if (ix == l4 || ix == l4 + 32'd1)   sport <= {sport[7:0], in_data};
        if (ix == l4 + 32'd2 || ix == l4 + 32'd3) dport <= {dport[7:0], in_data};
      end
    end
  end

  logic [MC_N-1:0]   mc_hit;
  logic [RULE_N-1:0] rule_hit;
  logic              decision;

  wire ipv4   = len >= 32'd15 && etype == 16'h0800 && ihl >= 4'd5;
  wire has_sa = ipv4 && len >= 32'd30;
  wire has_da = ipv4 && len >= 32'd34;
  wire l4_ok  = ipv4 && len >= 32'd24 && (proto == 8'd6 || proto == 8'd17);
  wire has_sp = l4_ok && len >= l4 + 32'd2;
  wire has_dp = l4_ok && len >= l4 + 32'd4;
  wire l2_ok  = len >= 32'd6 && (dmac == sta_mac || |mc_hit);

  always_comb begin
    for (int i = 0; i < MC_N; i++) mc_hit[i] = mc_vld[i] && mc_addr[i] == dmac;
    for (int i = 0; i < RULE_N; i++) begin
      case (rule_kind[i])
        2'd0:    rule_hit[i] = has_sa && sip == rule_val[i];
        2'd1:    rule_hit[i] = has_da && dip == rule_val[i];
        2'd2:    rule_hit[i] = has_sp && sport == rule_val[i][15:0];
        default: rule_hit[i] = has_dp && dport == rule_val[i][15:0];
      endcase
      rule_hit[i] = rule_hit[i] && rule_en[i];
    end
    decision = dflt_pass;
    for (int i = RULE_N - 1; i >= 0; i--)
      if (rule_hit[i]) decision = rule_act[i];
  end

  assign verdict_valid = pend;
  assign verdict_pass  = pend && !err_q && l2_ok && decision;
endmodule

// File: rtl/eth_frame_filter_chk.sv
module eth_frame_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_sof,
  input logic in_eof,
  input logic in_err,
  input logic verdict_valid,
  input logic verdict_pass
);
  assert_verdict_after_eof_R1: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(in_valid && in_eof));

  assert_pass_only_with_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_pass |-> verdict_valid);

  assert_runt_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_sof && in_eof) |-> verdict_valid && !verdict_pass);

  assert_error_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && $past(in_valid && in_eof && in_err) |-> !verdict_pass);
endmodule

bind eth_frame_filter eth_frame_filter_chk i_chk (.*);

// File: tb/test_eth_frame_filter.sv
module test_eth_frame_filter;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0]  in_data = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        verdict_valid, verdict_pass;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] fb [0:127];
  int flen;

  localparam logic [47:0] STA = 48'h0011_2233_4455;

  eth_frame_filter i_eth_frame_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .verdict_valid(verdict_valid), .verdict_pass(verdict_pass));

  always #(PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_rule(input int i, input logic [31:0] v, input int kind, input bit act, input bit en);
    wr(24 + 2 * i, v);
    wr(25 + 2 * i, {27'd0, en, act, 1'b0, 2'(kind)});
  endtask

  task automatic clear_rules();
    for (int i = 0; i < 4; i++) set_rule(i, 32'd0, 0, 1'b0, 1'b0);
  endtask

  task automatic build(input logic [47:0] da, input logic [15:0] et, input logic [3:0] hl,
                       input logic [7:0] pr, input logic [31:0] sa, input logic [31:0] dst,
                       input logic [15:0] sp, input logic [15:0] dp);
    int l4;
    for (int i = 0; i < 128; i++) fb[i] = 8'h00;
    for (int i = 0; i < 6; i++) fb[i] = da[47 - 8 * i -: 8];
    for (int i = 6; i < 12; i++) fb[i] = 8'(8'hA0 + i);
    fb[12] = et[15:8]; fb[13] = et[7:0];
    fb[14] = {4'h4, hl};
    fb[23] = pr;
    for (int i = 0; i < 4; i++) fb[26 + i] = sa[31 - 8 * i -: 8];
    for (int i = 0; i < 4; i++) fb[30 + i] = dst[31 - 8 * i -: 8];
    l4 = 14 + 4 * int'(hl);
    fb[l4] = sp[15:8]; fb[l4 + 1] = sp[7:0];
    fb[l4 + 2] = dp[15:8]; fb[l4 + 3] = dp[7:0];
    flen = (l4 + 8 > 60) ? l4 + 8 : 60;
  endtask

  task automatic send(input int n, input int err_pos, output logic vv, output logic vp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1);
      in_err = (i == err_pos); in_data = fb[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    vv = verdict_valid; vp = verdict_pass;
  endtask

  task automatic t_reset();
    check("R1", "verdict_valid after reset", verdict_valid, 1'b0);
    check("R1", "verdict_pass after reset", verdict_pass, 1'b0);
  endtask

  task automatic t_station();
    logic vv, vp;
    wr(0, STA[31:0]); wr(1, {16'd0, STA[47:32]}); // R12 map
    wr(2, 32'd0);
    build(STA, 16'h0806, 4'd5, 8'd6, 0, 0, 0, 0);
    send(flen, -1, vv, vp);
    check("R1", "verdict pulse", vv, 1'b1);
    check("R8", "station, default discard", vp, 1'b0);
    wr(2, 32'd1);
    send(flen, -1, vv, vp);
    check("R2", "station, default pass", vp, 1'b1);
  endtask

  task automatic t_mismatch();
    logic vv, vp;
    build(STA + 48'd1, 16'h0806, 4'd5, 8'd6, 0, 0, 0, 0);
    send(flen, -1, vv, vp);
    check("R4", "foreign unicast dropped", vp, 1'b0);
  endtask

  task automatic t_multicast();
    logic vv, vp;
    build(48'h0100_5E00_0001, 16'h0806, 4'd5, 8'd6, 0, 0, 0, 0);
    send(flen, -1, vv, vp);
    check("R4", "unregistered multicast", vp, 1'b0);
    wr(8 + 2 * 3, 32'h5E00_0001); wr(9 + 2 * 3, 32'h0001_0100);
    send(flen, -1, vv, vp);
    check("R3", "multicast entry 3 valid", vp, 1'b1);
    wr(9 + 2 * 3, 32'h0000_0100);
    send(flen, -1, vv, vp);
    check("R3", "multicast entry 3 invalid", vp, 1'b0);
    build(48'h0100_5E7F_FFFA, 16'h0806, 4'd5, 8'd6, 0, 0, 0, 0);
    wr(8 + 2 * 7, 32'h5E7F_FFFA); wr(9 + 2 * 7, 32'h0001_0100);
    send(flen, -1, vv, vp);
    check("R3", "multicast entry 7 valid", vp, 1'b1);
  endtask

  task automatic t_src_ip();
    logic vv, vp;
    wr(2, 32'd1); clear_rules();
    set_rule(1, 32'hC0A8_0001, 0, 1'b0, 1'b1);
    build(STA, 16'h0800, 4'd5, 8'd6, 32'hC0A8_0001, 32'h0A00_0005, 16'd1000, 16'd80);
    send(flen, -1, vv, vp);
    check("R6", "source IP discard rule hit", vp, 1'b0);
    build(STA, 16'h0800, 4'd5, 8'd6, 32'hC0A8_0002, 32'h0A00_0005, 16'd1000, 16'd80);
    send(flen, -1, vv, vp);
    check("R8", "source IP miss, default pass", vp, 1'b1);
  endtask

  task automatic t_order();
    logic vv, vp;
    wr(2, 32'd0); clear_rules();
    set_rule(0, 32'h0A00_0005, 1, 1'b1, 1'b1);
    set_rule(2, 32'h0A00_0005, 1, 1'b0, 1'b1);
    build(STA, 16'h0800, 4'd5, 8'd17, 32'h0102_0304, 32'h0A00_0005, 16'd1, 16'd2);
    send(flen, -1, vv, vp);
    check("R7", "lowest index wins (pass)", vp, 1'b1);
    set_rule(0, 32'h0A00_0005, 1, 1'b1, 1'b0);
    wr(2, 32'd1);
    send(flen, -1, vv, vp);
    check("R9", "disabled rule skipped, next discards", vp, 1'b0);
  endtask

  task automatic t_ports();
    logic vv, vp;
    wr(2, 32'd0); clear_rules();
    set_rule(0, 32'd80, 3, 1'b1, 1'b1);
    build(STA, 16'h0800, 4'd6, 8'd6, 32'h0102_0304, 32'h0506_0708, 16'd1234, 16'd80);
    send(flen, -1, vv, vp);
    check("R5", "TCP dst port behind options", vp, 1'b1);
    build(STA, 16'h0800, 4'd6, 8'd1, 32'h0102_0304, 32'h0506_0708, 16'd1234, 16'd80);
    send(flen, -1, vv, vp);
    check("R5", "ICMP ports not examined", vp, 1'b0);
    clear_rules();
    set_rule(3, 32'h0000_14E9, 2, 1'b1, 1'b1);
    build(STA, 16'h0800, 4'd5, 8'd17, 32'h0102_0304, 32'h0506_0708, 16'd5353, 16'd53);
    send(flen, -1, vv, vp);
    check("R6", "UDP source port rule", vp, 1'b1);
    build(STA, 16'h0800, 4'd4, 8'd17, 32'h0102_0304, 32'h0506_0708, 16'd5353, 16'd53);
    send(flen, -1, vv, vp);
    check("R5", "IHL below 5 not IPv4", vp, 1'b0);
  endtask

  task automatic t_short();
    logic vv, vp;
    wr(2, 32'd0); clear_rules();
    set_rule(0, 32'd80, 3, 1'b1, 1'b1);
    build(STA, 16'h0800, 4'd5, 8'd6, 32'h0102_0304, 32'h0506_0708, 16'd1234, 16'd80);
    send(37, -1, vv, vp);
    check("R10", "frame ends inside dst port", vp, 1'b0);
    send(38, -1, vv, vp);
    check("R10", "frame ends at dst port", vp, 1'b1);
    clear_rules();
    set_rule(1, 32'h0102_0304, 0, 1'b1, 1'b1);
    send(29, -1, vv, vp);
    check("R10", "frame ends inside source IP", vp, 1'b0);
  endtask

  task automatic t_error();
    logic vv, vp;
    wr(2, 32'd1); clear_rules();
    build(STA, 16'h0806, 4'd5, 8'd6, 0, 0, 0, 0);
    send(flen, flen - 1, vv, vp);
    check("R11", "error on last byte", vp, 1'b0);
    send(flen, 3, vv, vp);
    check("R11", "error mid-frame", vp, 1'b0);
    send(flen, -1, vv, vp);
    check("R11", "error not carried to next frame", vp, 1'b1);
  endtask

  task automatic t_non_ipv4();
    logic vv, vp;
    wr(2, 32'd1); clear_rules();
    set_rule(0, 32'h0A00_0005, 1, 1'b0, 1'b1);
    build(STA, 16'h86DD, 4'd5, 8'd6, 32'h0, 32'h0A00_0005, 0, 0);
    send(flen, -1, vv, vp);
    check("R8", "non-IPv4 ignores rules", vp, 1'b1);
  endtask

  task automatic t_runt_and_outside();
    logic vv, vp;
    logic seen;
    wr(2, 32'd1); clear_rules();
    build(STA, 16'h0806, 4'd5, 8'd6, 0, 0, 0, 0);
    send(1, -1, vv, vp);
    check("R4", "one-byte frame verdict", vv, 1'b1);
    check("R4", "one-byte frame dropped", vp, 1'b0);
    seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      seen = seen | verdict_valid;
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 2); in_data = 8'h55;
    end
    @(negedge clk);
    seen = seen | verdict_valid;
    in_valid = 1'b0; in_eof = 1'b0;
    @(negedge clk);
    seen = seen | verdict_valid;
    check("R1", "no verdict for bytes outside a frame", seen, 1'b0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_station();
    t_mismatch();
    t_multicast();
    t_src_ip();
    t_order();
    t_ports();
    t_short();
    t_error();
    t_non_ipv4();
    t_runt_and_outside();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule